// File: doc/BRIEF.md
# Single-to-Dual Pixel Stream Splitter

This block sits in front of a display link serializer. Each input clock it takes one 28-bit pixel word, which holds the colour data and the horizontal sync, vertical sync and data-enable bits. It then routes the word onto one or two parallel output buses, A and B. A two-bit mode input selects the routing. In single mode, bus A alone follows the input. In dual mode, two independent input words pass straight through. In split mode, consecutive pixels are paired so that each bus carries one pixel every two input clocks. A reserved mode code parks both buses.

In split mode the first pixel of each pair is held in a register until its partner arrives. Both buses then update in the same cycle, together with a one-cycle strobe, so the two halves stay aligned. The pairing phase restarts at every low-to-high transition of data enable, which puts the first active pixel of a line on bus A. Blanking is expected to last an even number of clocks. If data enable rises while a partner pixel is still awaited, the block realigns anyway and sets a sticky flag. An output vector reports which buses currently carry valid data.

Top module: `pix_pair_split`

## Requirements
- R1: While reset is asserted and after its release before any clock, both buses, the strobe, the bus-enable vector and the misalignment flag are all zero.
- R2: Mode code 2'b00 (single): one clock after an input word is presented, bus A equals it, bus B is zero, the strobe is high and the bus-enable vector is 2'b01 (bit 0 = bus A, bit 1 = bus B).
- R3: Mode code 2'b10 (dual): one clock after presentation, bus A equals input A, bus B equals input B, the strobe is high and the bus-enable vector is 2'b11.
- R4: Mode code 2'b11 (reserved): one clock later, both buses are zero, the strobe is low and the bus-enable vector is 2'b00.
- R5: Mode code 2'b01 (split): pixels from input A are paired in arrival order. One clock after the second pixel of a pair, bus A shows the first pixel, bus B shows the second, and the strobe is high for that single cycle. The bus-enable vector is 2'b11.
- R6: In split mode, a pixel whose data-enable bit (bit 27) is 1 while the previous input had it 0 always starts a new pair, so it appears on bus A.
- R7: In split mode, pairing continues through blanking: words with data enable low are paired and output like active pixels.
- R8: Bits 27 (data enable), 26 (vertical sync) and 25 (horizontal sync) of each routed word reach the output bus unchanged.
- R9: The misalignment flag sets when, in split mode, data enable rises while a pair is half-filled. It stays set in every mode until reset.
- R10: Entering split mode from any other mode starts with an empty pair, so the first pixel in split mode goes to bus A.
- R11: In split mode, on cycles without a strobe both buses hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Routing select: 00 single, 01 split, 10 dual, 11 reserved |
| pix_a_in | input | 28 | Primary pixel word (bit 27 DE, 26 VS, 25 HS) |
| pix_b_in | input | 28 | Second pixel word, used in dual mode only |
| bus_a_out | output | 28 | Output bus A |
| bus_b_out | output | 28 | Output bus B |
| out_stb | output | 1 | High in each cycle the buses carry a new word (pair) |
| bus_en | output | 2 | Valid buses: bit 0 bus A, bit 1 bus B |
| misalign | output | 1 | Sticky flag: data enable rose with a half-filled pair |

## Verification
The pairing assertions assume the mode input stays in split mode for the two cycles of a pair. They also take the data-enable transition as seen at the port, one cycle after the previous word. Mode switches that cut a pair short are covered only by the rules that hold in any mode. The random stimulus builds split-mode lines from even-length active runs and even-length blanking, so the misalignment flag is set by one directed odd-length run and by nothing else. Stretches in the other modes are kept separate from the lines, with random lengths.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [1:0] {
    MD_SINGLE = 2'b00,
    MD_SPLIT  = 2'b01,
    MD_DUAL   = 2'b10,
    MD_RSVD   = 2'b11
  } pps_mode_e;

  localparam int NUM_LANES = 2;

  localparam logic [NUM_LANES-1:0] EN_NONE = 2'b00;
  localparam logic [NUM_LANES-1:0] EN_A    = 2'b01;
  localparam logic [NUM_LANES-1:0] EN_AB   = 2'b11;

endpackage

// File: rtl/pps_phase.sv
// Pair-phase tracker: restarts at data-enable rise, flags a rise mid-pair.
module pps_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic split_en,
  input  logic de,
  output logic eff_ph,
  output logic misalign
);

  logic ph_q, ph_d;
  logic de_q;
  logic mis_q, mis_d;
  logic de_rise;

  always_comb begin
    de_rise = de & ~de_q;
    eff_ph  = de_rise ? 1'b0 : ph_q;
    ph_d    = split_en ? ~eff_ph : 1'b0;
    mis_d   = mis_q | (split_en & de_rise & ph_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 1'b0;
      de_q  <= 1'b0;
      mis_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      de_q  <= de;
      mis_q <= mis_d;
    end
  end

  assign misalign = mis_q;

endmodule

// File: rtl/pps_route.sv
// Next-state routing for both output lanes and the pair-hold register.
module pps_route
  import pps_pkg::*;
#(
  parameter int PIX_W = 28
) (
  input  pps_mode_e                         mode_i,
  input  logic                              eff_ph,
  input  logic [PIX_W-1:0]                  pix_a,
  input  logic [PIX_W-1:0]                  pix_b,
  input  logic [PIX_W-1:0]                  hold_q,
  output logic [NUM_LANES-1:0][PIX_W-1:0]   lane_d,
  output logic                              lane_ce,
  output logic                              hold_ce,
  output logic                              stb_d,
  output logic [NUM_LANES-1:0]              en_d
);

  always_comb begin
    lane_d  = '0;
    lane_ce = 1'b0;
    hold_ce = 1'b0;
    stb_d   = 1'b0;
    en_d    = EN_NONE;
    unique case (mode_i)
      MD_SINGLE: begin
        lane_d[0] = pix_a;
        lane_ce   = 1'b1;
        stb_d     = 1'b1;
        en_d      = EN_A;
      end
      MD_DUAL: begin
        lane_d[0] = pix_a;
        lane_d[1] = pix_b;
        lane_ce   = 1'b1;
        stb_d     = 1'b1;
        en_d      = EN_AB;
      end
      MD_SPLIT: begin
        en_d = EN_AB;
        if (!eff_ph) begin
          hold_ce = 1'b1;
        end else begin
          lane_d[0] = hold_q;
          lane_d[1] = pix_a;
          lane_ce   = 1'b1;
          stb_d     = 1'b1;
        end
      end
      default: begin
        lane_ce = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/pps_lane_reg.sv
// One output lane register with explicit clock enable.
module pps_lane_reg #(
  parameter int PIX_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic [PIX_W-1:0] d,
  output logic [PIX_W-1:0] q
);

  logic [PIX_W-1:0] q_q, q_d;

  always_comb q_d = ce ? d : q_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q = q_q;

endmodule

// File: rtl/pix_pair_split.sv
module pix_pair_split
  import pps_pkg::*;
#(
  parameter int PIX_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [PIX_W-1:0] pix_a_in,
  input  logic [PIX_W-1:0] pix_b_in,
  output logic [PIX_W-1:0] bus_a_out,
  output logic [PIX_W-1:0] bus_b_out,
  output logic             out_stb,
  output logic [1:0]       bus_en,
  output logic             misalign
);

  localparam int DE_BIT = PIX_W - 1;

  pps_mode_e mode_e;
  logic      split_en;
  logic      eff_ph;

  logic [NUM_LANES-1:0][PIX_W-1:0] lane_d;
  logic [NUM_LANES-1:0][PIX_W-1:0] lane_q;
  logic                            lane_ce;
  logic                            hold_ce;
  logic [PIX_W-1:0]                hold_q, hold_d;
  logic                            stb_d, stb_q;
  logic [NUM_LANES-1:0]            en_d, en_q;

  assign mode_e   = pps_mode_e'(mode);
  assign split_en = (mode_e == MD_SPLIT);

  pps_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .split_en (split_en),
    .de       (pix_a_in[DE_BIT]),
    .eff_ph   (eff_ph),
    .misalign (misalign)
  );

  pps_route #(.PIX_W(PIX_W)) u_route (
    .mode_i  (mode_e),
    .eff_ph  (eff_ph),
    .pix_a   (pix_a_in),
    .pix_b   (pix_b_in),
    .hold_q  (hold_q),
    .lane_d  (lane_d),
    .lane_ce (lane_ce),
    .hold_ce (hold_ce),
    .stb_d   (stb_d),
    .en_d    (en_d)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    pps_lane_reg #(.PIX_W(PIX_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .ce    (lane_ce),
      .d     (lane_d[g]),
      .q     (lane_q[g])
    );
  end

  always_comb hold_d = hold_ce ? pix_a_in : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      stb_q  <= 1'b0;
      en_q   <= EN_NONE;
    end else begin
      hold_q <= hold_d;
      stb_q  <= stb_d;
      en_q   <= en_d;
    end
  end

  assign bus_a_out = lane_q[0];
  assign bus_b_out = lane_q[1];
  assign out_stb   = stb_q;
  assign bus_en    = en_q;

endmodule

// File: rtl/pix_pair_split_chk.sv
module pix_pair_split_chk #(
  parameter int PIX_W = 28
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic [PIX_W-1:0] pix_a_in,
  input logic [PIX_W-1:0] pix_b_in,
  input logic [PIX_W-1:0] bus_a_out,
  input logic [PIX_W-1:0] bus_b_out,
  input logic             out_stb,
  input logic [1:0]       bus_en,
  input logic             misalign
);

  localparam int DE_BIT = PIX_W - 1;

  assert_single_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> (bus_a_out == $past(pix_a_in) && bus_b_out == '0
                          && out_stb && bus_en == 2'b01));

  assert_dual_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |=> (bus_a_out == $past(pix_a_in) && bus_b_out == $past(pix_b_in)
                          && out_stb && bus_en == 2'b11));

  assert_rsvd_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |=> (bus_a_out == '0 && bus_b_out == '0 && !out_stb && bus_en == 2'b00));

  assert_split_stb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && out_stb) |=> (!out_stb && bus_en == 2'b11));

  assert_split_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && pix_a_in[DE_BIT] && !$past(pix_a_in[DE_BIT])) ##1 (mode == 2'b01)
      |=> (out_stb && bus_a_out == $past(pix_a_in, 2) && bus_b_out == $past(pix_a_in)));

  assert_mis_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |=> misalign);

  assert_split_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'b01 && !out_stb) |-> ($stable(bus_a_out) && $stable(bus_b_out)));

endmodule

bind pix_pair_split pix_pair_split_chk #(.PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .pix_a_in  (pix_a_in),
  .pix_b_in  (pix_b_in),
  .bus_a_out (bus_a_out),
  .bus_b_out (bus_b_out),
  .out_stb   (out_stb),
  .bus_en    (bus_en),
  .misalign  (misalign)
);

// File: tb/pix_pair_split_tb.sv
module pix_pair_split_tb;

  localparam int W = 28;
  localparam int VW = 2 * W + 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   mode;
  logic [W-1:0] pix_a, pix_b;
  logic [W-1:0] bus_a, bus_b;
  logic         stb;
  logic [1:0]   en;
  logic         mis;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [W-1:0] m_a, m_b, m_hold;
  logic         m_stb, m_ph, m_dep, m_mis;
  logic [1:0]   m_en;

  always #5 clk = ~clk;

  pix_pair_split #(.PIX_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pix_a_in(pix_a), .pix_b_in(pix_b),
    .bus_a_out(bus_a), .bus_b_out(bus_b), .out_stb(stb), .bus_en(en), .misalign(mis)
  );

  task automatic chk(input bit ok, input string tag, input logic [VW-1:0] act,
                     input logic [VW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rpix(input bit de, input bit vs, input bit hs);
    logic [W-4:0] body;
    body = W'($urandom) ;
    return {de, vs, hs, body};
  endfunction

  function automatic string tag_of(input logic [1:0] m);
    case (m)
      2'b00:   return "R2";
      2'b01:   return "R5";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic model_reset();
    m_a = '0; m_b = '0; m_hold = '0; m_stb = 0; m_ph = 0; m_dep = 0; m_mis = 0; m_en = 2'b00;
  endtask

  task automatic model_step();
    logic de, rise, eph;
    de   = pix_a[W-1];
    rise = de & ~m_dep;
    case (mode)
      2'b00: begin m_a = pix_a; m_b = '0;    m_stb = 1; m_en = 2'b01; m_ph = 0; end
      2'b10: begin m_a = pix_a; m_b = pix_b; m_stb = 1; m_en = 2'b11; m_ph = 0; end
      2'b11: begin m_a = '0;    m_b = '0;    m_stb = 0; m_en = 2'b00; m_ph = 0; end
      default: begin
        m_en = 2'b11;
        eph  = rise ? 1'b0 : m_ph;
        if (rise && m_ph) m_mis = 1;
        if (!eph) begin
          m_hold = pix_a; m_stb = 0; m_ph = 1;
        end else begin
          m_a = m_hold; m_b = pix_a; m_stb = 1; m_ph = 0;
        end
      end
    endcase
    m_dep = de;
  endtask

  task automatic cyc(input logic [1:0] m, input logic [W-1:0] a, input logic [W-1:0] b);
    mode = m; pix_a = a; pix_b = b;
    @(posedge clk);
    model_step();
    #2;
    chk({bus_a, bus_b, stb, en, mis} === {m_a, m_b, m_stb, m_en, m_mis}, tag_of(m),
        {bus_a, bus_b, stb, en, mis}, {m_a, m_b, m_stb, m_en, m_mis});
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic [W-1:0] p1, p2, x1, x2, x3, y1, y2, z1, z2;
    logic [W-1:0] sa, sb;
    void'($urandom(32'h0005_eed1));
    rst_n = 0; mode = 2'b01; pix_a = {1'b1, 27'h5a5a5a5}; pix_b = '1;
    model_reset();
    repeat (3) @(posedge clk);
    #2;
    chk({bus_a, bus_b, stb, en, mis} === '0, "R1", {bus_a, bus_b, stb, en, mis}, '0);
    rst_n = 1;
    pix_a = '0;
    @(posedge clk); model_step(); #2;

    // R2 single, R3 dual, R4 reserved
    for (int i = 0; i < 5; i++) cyc(2'b00, rpix(1, 0, 0), rpix(1, 1, 1));
    for (int i = 0; i < 5; i++) cyc(2'b10, rpix(1, 1, 0), rpix(0, 1, 1));
    for (int i = 0; i < 3; i++) cyc(2'b11, rpix(1, 1, 1), rpix(1, 1, 1));

    // R10: enter split from single mode with DE already high (no rise)
    cyc(2'b00, rpix(1, 0, 0), '0);
    p1 = rpix(1, 0, 1); p2 = rpix(1, 1, 0);
    cyc(2'b01, p1, '0);
    cyc(2'b01, p2, '0);
    chk(bus_a == p1 && bus_b == p2 && stb, "R10", {bus_a, bus_b, 4'h0}, {p1, p2, 4'h0});
    // R8: control bits carried on both buses
    chk({bus_a[27:25], bus_b[27:25]} == {3'b101, 3'b110}, "R8",
        VW'({bus_a[27:25], bus_b[27:25]}), VW'({3'b101, 3'b110}));

    // R7: blanking words are still paired; R11 hold on non-strobe cycle
    y1 = rpix(0, 1, 1); y2 = rpix(0, 0, 1);
    sa = bus_a; sb = bus_b;
    cyc(2'b01, y1, '0);
    chk(bus_a == sa && bus_b == sb && !stb, "R11", {bus_a, bus_b, 4'h0}, {sa, sb, 4'h0});
    cyc(2'b01, y2, '0);
    chk(bus_a == y1 && bus_b == y2, "R7", {bus_a, bus_b, 4'h0}, {y1, y2, 4'h0});

    // R6/R9: odd active run then even blanking forces a rise mid-pair
    cyc(2'b11, '0, '0);
    x1 = rpix(1, 0, 0); x2 = rpix(1, 0, 0); x3 = rpix(1, 0, 0);
    y1 = rpix(0, 0, 0); y2 = rpix(0, 0, 0);
    z1 = rpix(1, 1, 0); z2 = rpix(1, 0, 1);
    cyc(2'b01, x1, '0); cyc(2'b01, x2, '0); cyc(2'b01, x3, '0);
    cyc(2'b01, y1, '0); cyc(2'b01, y2, '0);
    chk(mis == 1'b0, "R9", VW'(mis), VW'(0));
    cyc(2'b01, z1, '0);
    chk(mis == 1'b1, "R9", VW'(mis), VW'(1));
    cyc(2'b01, z2, '0);
    chk(bus_a == z1 && bus_b == z2, "R6", {bus_a, bus_b, 4'h0}, {z1, z2, 4'h0});
    for (int i = 0; i < 4; i++) cyc(2'b10, rpix(0, 0, 0), rpix(0, 0, 0));
    chk(mis == 1'b1, "R9", VW'(mis), VW'(1));

    // Random: split-mode lines with even active and blanking lengths,
    // separated by random stretches in other modes.
    for (int f = 0; f < 60; f++) begin
      int act, blk;
      logic [1:0] om;
      if ($urandom_range(0, 3) == 0) begin
        om = 2'($urandom_range(0, 3));
        if (om == 2'b01) om = 2'b00;
        for (int i = 0; i < int'($urandom_range(1, 6)); i++)
          cyc(om, rpix(1'($urandom), 1'($urandom), 1'($urandom)), W'($urandom));
        cyc(2'b11, '0, '0);
      end
      act = 2 * $urandom_range(1, 8);
      blk = 2 * $urandom_range(1, 4);
      for (int i = 0; i < act; i++) cyc(2'b01, rpix(1, 0, 1'(i == 0)), W'($urandom));
      for (int i = 0; i < blk; i++) cyc(2'b01, rpix(0, 1'(i < 2), 0), W'($urandom));
    end

    done = 1'b1;
    summary();
  end

endmodule